// File: doc/BRIEF.md
# Precision-Controlled Significand Rounder

This block takes one arithmetic result held in the 80-bit extended layout and rounds its significand to the working precision the current control word asks for. The layout is a sign bit, a 15-bit biased exponent and a 64-bit significand with an explicit integer bit. Two extra bits come with the result from the arithmetic stage that produced it: a guard bit and a sticky bit. The control word gives a precision field and a rounding-mode field. The block reads these two fields and ignores every other bit of the word.

Shrinking the precision shortens only the significand. The kept part is rounded, and every position below the chosen width becomes zero. The exponent keeps its full 15-bit range, so a result outside the single or double exponent range is neither clamped nor flagged. A round-up that carries out of the top of the significand renormalises the result and bumps the exponent. If that bump reaches the reserved all-ones exponent, the result becomes infinity and an overflow flag is raised. A flag marks results that lost information. Zeros, infinities and NaNs pass through unchanged.

The input side offers one result per cycle with a valid strobe. The rounded result appears on registered outputs exactly one cycle later.

Top module: `sig_rounder`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. All result outputs are registered and are updated in that same cycle.
- R2: The precision is selected by `in_ctrl[9:8]`: 00 keeps 24 significand bits, 10 keeps 53 bits, 11 keeps 64 bits, and 01 behaves exactly as 11. Control bits other than 8 to 11 have no effect on the outputs.
- R3: At 24-bit precision `out_sig[39:0]` is zero, and at 53-bit precision `out_sig[10:0]` is zero, for every input that is not a special value.
- R4: When `in_ctrl[11:10]` is 00, the result is rounded to nearest, and ties go to the even value of the kept least significant bit.
- R5: When `in_ctrl[11:10]` is 01, the result is rounded toward minus infinity. When it is 10, the result is rounded toward plus infinity. In both cases the magnitude is incremented only when the sign matches the direction and some discarded information is nonzero.
- R6: When `in_ctrl[11:10]` is 11, the result is rounded toward zero: the significand is only truncated, and the exponent is unchanged.
- R7: A round-up that carries out of bit 63 produces significand 0x8000_0000_0000_0000 and an exponent one higher than the input exponent.
- R8: If that carried exponent equals 0x7FFF, the output is infinity (exponent 0x7FFF, significand 0x8000_0000_0000_0000, input sign) and `out_overflow` is 1. In every other case `out_overflow` is 0.
- R9: Without a carry, the output exponent equals the input exponent for every exponent value, including those outside the single or double range.
- R10: `out_inexact` is 1 exactly when a discarded significand bit, the guard bit or the sticky bit was nonzero, for an input that is not a special value.
- R11: An input with exponent 0x7FFF, or with exponent 0 and significand 0, is output unchanged, with `out_inexact` and `out_overflow` both 0.
- R12: While `rst_n` is low at a clock edge, every output is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input result is valid this cycle |
| in_sign | input | 1 | Sign of the input result |
| in_exp | input | 15 | Biased exponent of the input |
| in_sig | input | 64 | Significand of the input, explicit integer bit at bit 63 |
| in_guard | input | 1 | First bit below the significand |
| in_sticky | input | 1 | OR of all bits below the guard bit |
| in_ctrl | input | 16 | Control word: precision at [9:8], rounding mode at [11:10] |
| out_valid | output | 1 | Rounded result is valid |
| out_sign | output | 1 | Sign of the rounded result |
| out_exp | output | 15 | Exponent of the rounded result |
| out_sig | output | 64 | Rounded significand |
| out_inexact | output | 1 | Information was lost in rounding |
| out_overflow | output | 1 | The rounding carry reached infinity |

## Verification
The assertions check the following on every valid cycle:
- the one-cycle valid timing;
- the zeroed low significand bits at reduced precision;
- the unchanged passage of special values;
- the shape of an overflowed result;
- that truncation never changes the exponent;
- that an exact result equals its input.

The individual rounding decisions depend on data, and only the bench's scenarios can show them to be correct. These decisions are round to nearest with its ties broken to even, the sign-dependent directed modes, and the position of the carry into the exponent. The scenarios sweep every precision and mode code against significands placed at each rounding boundary, and compare every output field with an arithmetic model.

// File: rtl/rnd_pkg.sv
// Package: shared types for the significand rounder.
// Assumes the 2-bit rounding-mode field encoding listed in the brief.
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_DOWN    = 2'b01,
        RM_UP      = 2'b10,
        RM_ZERO    = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/rnd_prec_decode.sv
// Module: turns the precision and rounding fields of the control word into
// a count of discarded significand bits and a rounding mode.
// Assumes precision code 01 is reserved and is treated as full precision.
module rnd_prec_decode
    import rnd_pkg::*;
#(
    parameter int SIG_W   = 64,
    parameter int SP_BITS = 24,
    parameter int DP_BITS = 53,
    parameter int DROP_W  = $clog2(SIG_W + 1)
) (
    input  logic [1:0]        pc_field,
    input  logic [1:0]        rc_field,
    output logic [DROP_W-1:0] drop,
    output rnd_mode_e         mode
);

    // Map the precision code to the number of low significand bits removed.
    always_comb begin
        case (pc_field)
            2'b00:   drop = DROP_W'(SIG_W - SP_BITS);
            2'b10:   drop = DROP_W'(SIG_W - DP_BITS);
            default: drop = '0;
        endcase
    end

    // The rounding-mode field maps directly onto the enum.
    assign mode = rnd_mode_e'(rc_field);

endmodule

// File: rtl/rnd_bit_extract.sv
// Module: splits the significand at the precision boundary. It yields the
// truncated significand, the kept LSB, the round bit and the folded sticky bit.
// Assumes drop < SIG_W. At drop = 0 the round and sticky bits come from the
// guard and sticky inputs.
module rnd_bit_extract #(
    parameter int SIG_W  = 64,
    parameter int DROP_W = $clog2(SIG_W + 1)
) (
    input  logic [SIG_W-1:0]  sig,
    input  logic              guard,
    input  logic              sticky,
    input  logic [DROP_W-1:0] drop,
    output logic [SIG_W-1:0]  trunc,
    output logic              lsb,
    output logic              rbit,
    output logic              sbit
);

    logic [SIG_W-1:0] low_mask;
    logic [SIG_W-1:0] sh_keep;
    logic [SIG_W-1:0] sh_round;

    // Build the mask of discarded positions and align the boundary bits.
    always_comb begin
        low_mask = (SIG_W'(1) << drop) - SIG_W'(1);
        trunc    = sig & ~low_mask;
        sh_keep  = sig >> drop;
        sh_round = sig >> DROP_W'(drop - DROP_W'(1));
        lsb      = sh_keep[0];
        if (drop == '0) begin
            rbit = guard;
            sbit = sticky;
        end else begin
            rbit = sh_round[0];
            sbit = (|(sig & (low_mask >> 1))) | guard | sticky;
        end
    end

endmodule

// File: rtl/rnd_incr_decide.sv
// Module: decides whether the kept significand is bumped by one unit, and
// whether any information was lost, from the LSB, round and sticky bits.
// Assumes the bits come from rnd_bit_extract for the same operand.
module rnd_incr_decide
    import rnd_pkg::*;
(
    input  rnd_mode_e mode,
    input  logic      sign,
    input  logic      lsb,
    input  logic      rbit,
    input  logic      sbit,
    output logic      inc,
    output logic      inexact
);

    // Apply the rounding rule of the selected mode.
    always_comb begin
        inexact = rbit | sbit;
        case (mode)
            RM_NEAREST: inc = rbit & (sbit | lsb);
            RM_DOWN:    inc = sign & inexact;
            RM_UP:      inc = ~sign & inexact;
            default:    inc = 1'b0;
        endcase
    end

endmodule

// File: rtl/sig_rounder.sv
// Module: top of the precision-controlled significand rounder. It rounds an
// extended-format result to 24, 53 or 64 significand bits and keeps the full
// exponent range. The output is registered one cycle after the input.
// Assumes the integer bit is explicit at bit SIG_W-1 and that the all-ones
// exponent encodes infinity or NaN.
module sig_rounder
    import rnd_pkg::*;
#(
    parameter int EXP_W   = 15,
    parameter int SIG_W   = 64,
    parameter int CW_W    = 16,
    parameter int PC_LO   = 8,
    parameter int RC_LO   = 10,
    parameter int SP_BITS = 24,
    parameter int DP_BITS = 53
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sign,
    input  logic [EXP_W-1:0] in_exp,
    input  logic [SIG_W-1:0] in_sig,
    input  logic             in_guard,
    input  logic             in_sticky,
    input  logic [CW_W-1:0]  in_ctrl,
    output logic             out_valid,
    output logic             out_sign,
    output logic [EXP_W-1:0] out_exp,
    output logic [SIG_W-1:0] out_sig,
    output logic             out_inexact,
    output logic             out_overflow
);

    localparam int DROP_W = $clog2(SIG_W + 1);
    localparam int SP_LOW = SIG_W - SP_BITS;
    localparam int DP_LOW = SIG_W - DP_BITS;
    localparam logic [SIG_W-1:0] SIG_ONE = {1'b1, {(SIG_W-1){1'b0}}};

    logic [DROP_W-1:0] drop;
    rnd_mode_e         mode;
    logic [SIG_W-1:0]  trunc;
    logic              lsb, rbit, sbit, inc, inexact;
    logic              special;
    logic [SIG_W:0]    sum;
    logic [EXP_W-1:0]  exp_up;
    logic              unused_ctrl;

    logic             nx_sign, nx_inexact, nx_overflow;
    logic [EXP_W-1:0] nx_exp;
    logic [SIG_W-1:0] nx_sig;

    assign unused_ctrl = ^{in_ctrl[CW_W-1:RC_LO+2], in_ctrl[PC_LO-1:0]};

    rnd_prec_decode #(
        .SIG_W(SIG_W), .SP_BITS(SP_BITS), .DP_BITS(DP_BITS), .DROP_W(DROP_W)
    ) u_dec (
        .pc_field(in_ctrl[PC_LO+1:PC_LO]),
        .rc_field(in_ctrl[RC_LO+1:RC_LO]),
        .drop(drop),
        .mode(mode)
    );

    rnd_bit_extract #(.SIG_W(SIG_W), .DROP_W(DROP_W)) u_ext (
        .sig(in_sig), .guard(in_guard), .sticky(in_sticky), .drop(drop),
        .trunc(trunc), .lsb(lsb), .rbit(rbit), .sbit(sbit)
    );

    rnd_incr_decide u_inc (
        .mode(mode), .sign(in_sign), .lsb(lsb), .rbit(rbit), .sbit(sbit),
        .inc(inc), .inexact(inexact)
    );

    // Add one unit in the kept LSB position and resolve carry, overflow and specials.
    always_comb begin
        special = (in_exp == '1) || ((in_exp == '0) && (in_sig == '0));
        sum     = {1'b0, trunc} + ({{SIG_W{1'b0}}, inc} << drop);
        exp_up  = in_exp + EXP_W'(1);
        nx_sign     = in_sign;
        nx_exp      = in_exp;
        nx_sig      = sum[SIG_W-1:0];
        nx_inexact  = inexact;
        nx_overflow = 1'b0;
        if (special) begin
            nx_sig     = in_sig;
            nx_inexact = 1'b0;
        end else if (sum[SIG_W]) begin
            nx_sig      = SIG_ONE;
            nx_exp      = exp_up;
            nx_overflow = (exp_up == '1);
        end
    end

    // Output register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid    <= 1'b0;
            out_sign     <= 1'b0;
            out_exp      <= '0;
            out_sig      <= '0;
            out_inexact  <= 1'b0;
            out_overflow <= 1'b0;
        end else begin
            out_valid    <= in_valid;
            out_sign     <= nx_sign;
            out_exp      <= nx_exp;
            out_sig      <= nx_sig;
            out_inexact  <= nx_inexact;
            out_overflow <= nx_overflow;
        end
    end

    // R1: valid follows the input strobe by one cycle.
    p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3: low bits below the reduced precision are zero.
    p_sp_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !special && in_ctrl[PC_LO+1:PC_LO] == 2'b00)
        |=> (out_sig[SP_LOW-1:0] == '0));
    p_dp_low_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !special && in_ctrl[PC_LO+1:PC_LO] == 2'b10)
        |=> (out_sig[DP_LOW-1:0] == '0));

    // R6: truncation never moves the exponent.
    p_trunc_exp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ctrl[RC_LO+1:RC_LO] == 2'b11)
        |=> (out_exp == $past(in_exp) && !out_overflow));

    // R8: an overflowed result is a well-formed infinity.
    p_ovf_inf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_overflow) |-> (out_exp == '1 && out_sig == SIG_ONE));

    // R10: an exact result reproduces the input value.
    p_exact_same_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_inexact) |-> (out_sig == $past(in_sig) && out_exp == $past(in_exp)));

    // R11: special values pass through unchanged and raise no flag.
    p_special_pass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && special) |=> (out_sig == $past(in_sig) && out_exp == $past(in_exp)
                                   && !out_inexact && !out_overflow));

endmodule

// File: tb/sig_rounder_test.sv
module sig_rounder_test;

    typedef struct packed {
        logic        sign;
        logic [14:0] e;
        logic [63:0] s;
        logic        inx;
        logic        ovf;
        logic        carry;
        logic        spec;
    } res_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sign = 1'b0;
    logic [14:0] in_exp = '0;
    logic [63:0] in_sig = '0;
    logic        in_guard = 1'b0;
    logic        in_sticky = 1'b0;
    logic [15:0] in_ctrl = '0;
    logic        out_valid, out_sign, out_inexact, out_overflow;
    logic [14:0] out_exp;
    logic [63:0] out_sig;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sig_rounder uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
        .in_exp(in_exp), .in_sig(in_sig), .in_guard(in_guard), .in_sticky(in_sticky),
        .in_ctrl(in_ctrl), .out_valid(out_valid), .out_sign(out_sign),
        .out_exp(out_exp), .out_sig(out_sig), .out_inexact(out_inexact),
        .out_overflow(out_overflow)
    );

    // Arithmetic model: treat {sig,guard,sticky} as an integer and divide at the boundary.
    function automatic res_t model(input logic sg, input logic [14:0] e, input logic [63:0] s,
                                   input logic g, input logic st, input logic [15:0] cw);
        res_t r;
        int drop, n;
        logic [66:0] ext, q, rem, half, qn;
        logic up;
        r = '0;
        r.sign = sg;
        r.e = e;
        r.s = s;
        if (e == 15'h7FFF || (e == 0 && s == 0)) begin
            r.spec = 1'b1;
            return r;
        end
        drop = (cw[9:8] == 2'b00) ? 40 : (cw[9:8] == 2'b10) ? 11 : 0;
        n    = drop + 2;
        ext  = {1'b0, s, g, st};
        q    = ext >> n;
        rem  = ext - (q << n);
        half = 67'd1 << (n - 1);
        case (cw[11:10])
            2'b00: up = (rem > half) || (rem == half && q[0]);
            2'b01: up = sg && (rem != 0);
            2'b10: up = !sg && (rem != 0);
            default: up = 1'b0;
        endcase
        r.inx = (rem != 0);
        qn = q + 67'(up);
        if (qn == (67'd1 << (64 - drop))) begin
            r.carry = 1'b1;
            r.s = 64'h8000_0000_0000_0000;
            r.e = e + 15'd1;
            r.ovf = (r.e == 15'h7FFF);
        end else begin
            r.s = 64'(qn << drop);
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] pats [13];
        logic [14:0] exps [5];
        res_t m;
        string tg;
        pats = '{64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FF00_0000_0000,
                 64'hFFFF_FF80_0000_0000, 64'h8000_0180_0000_0000, 64'h8000_0080_0000_0000,
                 64'hFFFF_FFFF_FFFF_F800, 64'hFFFF_FFFF_FFFF_FC00, 64'hC000_0000_0000_0400,
                 64'hC000_0000_0000_0C00, 64'h0000_0000_0000_0001, 64'hA5A5_A5A5_A5A5_A5A5,
                 64'h0000_0000_0000_0000};
        exps = '{15'h0000, 15'h0001, 15'h3FFF, 15'h7FFE, 15'h7FFF};
        in_sig = 64'hFFFF_FFFF_FFFF_FFFF;
        in_exp = 15'h1234;
        in_valid = 1'b1;
        repeat (3) @(negedge clk);
        // R12: reset clears all outputs
        check("R12 valid", 64'(out_valid), 64'd0);
        check("R12 sig", out_sig, 64'd0);
        check("R12 exp", 64'(out_exp), 64'd0);
        check("R12 flags", 64'({out_sign, out_inexact, out_overflow}), 64'd0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle valid", 64'(out_valid), 64'd0);
        for (int pc = 0; pc < 4; pc++)
        for (int rc = 0; rc < 4; rc++)
        for (int sg = 0; sg < 2; sg++)
        for (int pi = 0; pi < 13; pi++)
        for (int ei = 0; ei < 5; ei++)
        for (int gs = 0; gs < 4; gs++) begin
            in_valid  = 1'b1;
            in_sign   = sg[0];
            in_sig    = pats[pi];
            in_exp    = exps[ei];
            in_guard  = gs[1];
            in_sticky = gs[0];
            // R2: unrelated control bits carry junk that must not matter
            in_ctrl   = {4'(pi + gs), rc[1:0], pc[1:0], 8'(pi * 37 + ei)};
            m = model(in_sign, in_exp, in_sig, in_guard, in_sticky, in_ctrl);
            @(negedge clk);
            if (m.spec) tg = "R11";
            else if (m.ovf) tg = "R8";
            else if (m.carry) tg = "R7";
            else if (pc == 1) tg = "R2";
            else if (rc == 0) tg = "R4";
            else if (rc == 3) tg = "R6";
            else tg = "R5";
            check("R1 valid", 64'(out_valid), 64'd1);
            check({tg, " sig"}, out_sig, m.s);
            check({tg, " exp"}, 64'(out_exp), 64'(m.e));
            check({tg, " sign"}, 64'(out_sign), 64'(m.sign));
            check("R10 inexact", 64'(out_inexact), 64'(m.inx));
            check("R8 overflow", 64'(out_overflow), 64'(m.ovf));
            if (!m.spec && !m.carry)
                check("R9 exp kept", 64'(out_exp), 64'(in_exp));
            if (!m.spec && pc == 0)
                check("R3 low24", 64'(out_sig[39:0]), 64'd0);
            if (!m.spec && pc == 2)
                check("R3 low53", 64'(out_sig[10:0]), 64'd0);
        end
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 valid drop", 64'(out_valid), 64'd0);
        finish_run();
    end

endmodule